// File: doc/BRIEF.md
# Oscillator Register Write Rule Checker

This block watches software writes aimed at a bank of oscillator control registers and records any write that breaks a sequencing rule. Each RC oscillator, the low-frequency oscillators and the high-frequency crystal report a synchronisation-busy flag. A write to a guarded register while its own busy flag is high counts as a violation. The crystal enable and disable commands are checked against the crystal's enabled-status and busy flags. The current-tune field of the low-frequency RC register counts as a violation only when it is rewritten with a different value while the reference-busy flag is high. The main crystal control register is exempt from all of these rules.

A violation raises bit 0 of a sticky flag register. The violating write still reaches its target, because the checker only observes. Software can set flag bits through a set register, clear them through a clear register and mask them through an enable register. A single registered interrupt line combines the flags with the enable mask. The registers themselves and the oscillators sit outside this block. To check the tune field, the checker keeps its own shadow copy of the field, which it updates on every write to the low-frequency RC register.

Top module: `osc_wr_checker`

## Requirements
- R1: After reset, `flags`, `ien` and `irq` are all 0, and the tune shadow is `TUNE_RST` (0).
- R2: A write to address 0x0 while `hirc_busy`=1, or to address 0x1 while `auxrc_busy`=1, sets flag bit 0. A busy flag belonging to another oscillator has no effect on these addresses.
- R3: A write to address 0x3, 0x4 or 0x5 (crystal startup, steady-state and timeout) while `xtal_busy`=1 sets flag bit 0. The same write with `xtal_busy`=0 does not.
- R4: A write to address 0x2 (main crystal control) never sets flag bit 0, whatever the state of the busy and status inputs.
- R5: A write to address 0x8 with data bit 0 (enable command) set sets flag bit 0 only when `xtal_on`=1 and `xtal_busy`=1.
- R6: A write to address 0x8 with data bit 1 (disable command) set sets flag bit 0 only when `xtal_on`=0 and `xtal_busy`=1.
- R7: A write to address 0x6 sets flag bit 0 when `lfrc_busy`=1. It also sets flag bit 0 when its data bits [11:8] (tune field) differ from the value last written there while `lfrc_ref_busy`=1. Rewriting an unchanged tune value never triggers this second rule.
- R8: A write to address 0x7 while `lfxt_busy`=1 sets flag bit 0.
- R9: `irq` is 1 exactly when some bit of `flags` and the same bit of `ien` are both 1. A write to address 0xB loads `ien` from data bits [NFLAG-1:0].
- R10: Flags are sticky. A write to address 0x9 ORs data bits into `flags`. A write to address 0xA clears the flags whose data bits are 1 and leaves every other flag unchanged.
- R11: A violating write at clock edge k sets flag bit 0 at edge k+1. A clear of bit 0 that takes effect at that same edge loses to the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| hirc_busy | input | 1 | High-frequency RC synchronisation busy |
| auxrc_busy | input | 1 | Auxiliary RC synchronisation busy |
| xtal_busy | input | 1 | High-frequency crystal synchronisation busy |
| xtal_on | input | 1 | High-frequency crystal enabled status |
| lfrc_busy | input | 1 | Low-frequency RC synchronisation busy |
| lfrc_ref_busy | input | 1 | Low-frequency RC reference busy |
| lfxt_busy | input | 1 | Low-frequency crystal synchronisation busy |
| flags | output | NFLAG | Sticky flag register (bit 0 is the rule-violation flag) |
| ien | output | NFLAG | Interrupt enable mask |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: a 4-bit address, 16-bit data, four flag bits and a 4-bit tune field at bits [11:8]. With four flags, the bench can set and clear the software-only flags 1 to 3 beside the hardware-driven bit 0. This shows that a clear touches only the selected bits, and that the interrupt follows whichever enabled flag is present. The tune field sits in the middle of the data word, so a rewrite that changes only the bits around the field shows that the changed-value rule looks at the field alone.

// File: rtl/osc_chk_pkg.sv
package osc_chk_pkg;
    // Guarded register word addresses
    localparam int unsigned ADR_HIRC     = 0;
    localparam int unsigned ADR_AUXRC    = 1;
    localparam int unsigned ADR_XT_MAIN  = 2;
    localparam int unsigned ADR_XT_START = 3;
    localparam int unsigned ADR_XT_STEAD = 4;
    localparam int unsigned ADR_XT_TMO   = 5;
    localparam int unsigned ADR_LFRC     = 6;
    localparam int unsigned ADR_LFXT     = 7;
    localparam int unsigned ADR_XT_CMD   = 8;
    // Flag register block
    localparam int unsigned ADR_FSET     = 9;
    localparam int unsigned ADR_FCLR     = 10;
    localparam int unsigned ADR_FIEN     = 11;
    // Command word bit positions
    localparam int unsigned CMD_EN_BIT   = 0;
    localparam int unsigned CMD_DIS_BIT  = 1;
    // Flag bit driven by the rule checker
    localparam int unsigned ERR_BIT      = 0;
endpackage

// File: rtl/osc_rule_decode.sv
module osc_rule_decode
    import osc_chk_pkg::*;
#(
    parameter int unsigned AW     = 4,
    parameter int unsigned TUNE_W = 4
) (
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic [TUNE_W-1:0] tune_new,
    input  logic [TUNE_W-1:0] tune_old,
    input  logic              hirc_busy,
    input  logic              auxrc_busy,
    input  logic              xtal_busy,
    input  logic              xtal_on,
    input  logic              lfrc_busy,
    input  logic              lfrc_ref_busy,
    input  logic              lfxt_busy,
    output logic              lfrc_hit,
    output logic              viol
);
    logic hit_hirc, hit_aux, hit_xcfg, hit_lfrc, hit_lfxt, hit_cmd;
    logic bad_busy, bad_cmd, bad_tune;

    always_comb begin
        hit_hirc = wr_en && (wr_addr == AW'(ADR_HIRC));
        hit_aux  = wr_en && (wr_addr == AW'(ADR_AUXRC));
        hit_xcfg = wr_en && ((wr_addr == AW'(ADR_XT_START)) ||
                             (wr_addr == AW'(ADR_XT_STEAD)) ||
                             (wr_addr == AW'(ADR_XT_TMO)));
        hit_lfrc = wr_en && (wr_addr == AW'(ADR_LFRC));
        hit_lfxt = wr_en && (wr_addr == AW'(ADR_LFXT));
        hit_cmd  = wr_en && (wr_addr == AW'(ADR_XT_CMD));

        // Each register is judged only against its own busy flag
        bad_busy = (hit_hirc && hirc_busy) || (hit_aux && auxrc_busy) ||
                   (hit_xcfg && xtal_busy) || (hit_lfrc && lfrc_busy) ||
                   (hit_lfxt && lfxt_busy);
        // Enable legal when off or idle; disable legal when on or idle
        bad_cmd  = hit_cmd && xtal_busy &&
                   ((cmd_en && xtal_on) || (cmd_dis && !xtal_on));
        bad_tune = hit_lfrc && lfrc_ref_busy && (tune_new != tune_old);

        lfrc_hit = hit_lfrc;
        viol     = bad_busy || bad_cmd || bad_tune;
    end
endmodule

// File: rtl/osc_flag_bank.sv
module osc_flag_bank
    import osc_chk_pkg::*;
#(
    parameter int unsigned AW    = 4,
    parameter int unsigned NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NFLAG-1:0] wr_bits,
    input  logic             hw_set,
    output logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] ien,
    output logic             irq
);
    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [NFLAG-1:0] ien;
        logic             irq;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_addr == AW'(ADR_FSET))) st_d.flags = st_q.flags | wr_bits;
        if (wr_en && (wr_addr == AW'(ADR_FCLR))) st_d.flags = st_q.flags & ~wr_bits;
        if (wr_en && (wr_addr == AW'(ADR_FIEN))) st_d.ien   = wr_bits;
        // Hardware set is applied last, so it beats a clear in the same cycle
        if (hw_set) st_d.flags[ERR_BIT] = 1'b1;
        st_d.irq = |(st_d.flags & st_d.ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign ien   = st_q.ien;
    assign irq   = st_q.irq;
endmodule

// File: rtl/osc_wr_checker.sv
module osc_wr_checker
    import osc_chk_pkg::*;
#(
    parameter int unsigned AW       = 4,
    parameter int unsigned DW       = 16,
    parameter int unsigned NFLAG    = 4,
    parameter int unsigned TUNE_LSB = 8,
    parameter int unsigned TUNE_W   = 4,
    parameter int unsigned TUNE_RST = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             hirc_busy,
    input  logic             auxrc_busy,
    input  logic             xtal_busy,
    input  logic             xtal_on,
    input  logic             lfrc_busy,
    input  logic             lfrc_ref_busy,
    input  logic             lfxt_busy,
    output logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] ien,
    output logic             irq
);
    localparam int unsigned TUNE_MSB = TUNE_LSB + TUNE_W - 1;

    typedef struct packed {
        logic              pend;
        logic [TUNE_W-1:0] tune;
    } ctl_t;

    ctl_t              st_d, st_q;
    logic              viol, lfrc_hit, pend_q;
    logic [TUNE_W-1:0] tune_new;

    assign tune_new = wr_data[TUNE_MSB:TUNE_LSB];

    osc_rule_decode #(.AW(AW), .TUNE_W(TUNE_W)) u_decode (
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .cmd_en        (wr_data[CMD_EN_BIT]),
        .cmd_dis       (wr_data[CMD_DIS_BIT]),
        .tune_new      (tune_new),
        .tune_old      (st_q.tune),
        .hirc_busy     (hirc_busy),
        .auxrc_busy    (auxrc_busy),
        .xtal_busy     (xtal_busy),
        .xtal_on       (xtal_on),
        .lfrc_busy     (lfrc_busy),
        .lfrc_ref_busy (lfrc_ref_busy),
        .lfxt_busy     (lfxt_busy),
        .lfrc_hit      (lfrc_hit),
        .viol          (viol)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pend = viol;
        // The write lands in its target even when it violates a rule
        if (lfrc_hit) st_d.tune = tune_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= 1'b0;
            st_q.tune <= TUNE_W'(TUNE_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;

    osc_flag_bank #(.AW(AW), .NFLAG(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bits (wr_data[NFLAG-1:0]),
        .hw_set  (pend_q),
        .flags   (flags),
        .ien     (ien),
        .irq     (irq)
    );
endmodule

// File: rtl/osc_wr_checker_sva.sv
module osc_wr_checker_sva
    import osc_chk_pkg::*;
#(
    parameter int unsigned AW    = 4,
    parameter int unsigned DW    = 16,
    parameter int unsigned NFLAG = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [DW-1:0]    wr_data,
    input logic             hirc_busy,
    input logic             xtal_busy,
    input logic             xtal_on,
    input logic             pend,
    input logic [NFLAG-1:0] flags,
    input logic [NFLAG-1:0] ien,
    input logic             irq
);
    assert_rc_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADR_HIRC) && hirc_busy) |=> pend);

    assert_main_exempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADR_XT_MAIN)) |=> !pend);

    assert_enable_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(ADR_XT_CMD) && wr_data[CMD_EN_BIT] && xtal_on && xtal_busy)
        |=> pend);

    assert_irq_combine_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(flags & ien)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[ERR_BIT] && !(wr_en && wr_addr == AW'(ADR_FCLR) && wr_data[ERR_BIT]))
        |=> flags[ERR_BIT]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> flags[ERR_BIT]);
endmodule

bind osc_wr_checker osc_wr_checker_sva #(.AW(AW), .DW(DW), .NFLAG(NFLAG)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hirc_busy (hirc_busy),
    .xtal_busy (xtal_busy),
    .xtal_on   (xtal_on),
    .pend      (pend_q),
    .flags     (flags),
    .ien       (ien),
    .irq       (irq)
);

// File: tb/osc_wr_checker_bench.sv
module osc_wr_checker_bench;
    localparam int AW = 4, DW = 16, NF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic hirc_busy = 0, auxrc_busy = 0, xtal_busy = 0, xtal_on = 0;
    logic lfrc_busy = 0, lfrc_ref_busy = 0, lfxt_busy = 0;
    logic [NF-1:0] flags, ien;
    logic irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    osc_wr_checker u_osc_wr_checker (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hirc_busy(hirc_busy), .auxrc_busy(auxrc_busy), .xtal_busy(xtal_busy),
        .xtal_on(xtal_on), .lfrc_busy(lfrc_busy), .lfrc_ref_busy(lfrc_ref_busy),
        .lfxt_busy(lfxt_busy), .flags(flags), .ien(ien), .irq(irq));

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic busy_all(input logic v);
        hirc_busy = v; auxrc_busy = v; xtal_busy = v;
        lfrc_busy = v; lfrc_ref_busy = v; lfxt_busy = v;
    endtask

    // Write and wait until a resulting flag update is visible (two edges)
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr_all();
        wr(10, 'hF);
    endtask

    task automatic t_reset();
        check("R1 flags", 8'(flags), 8'h0);
        check("R1 ien", 8'(ien), 8'h0);
        check("R1 irq", 8'(irq), 8'h0);
    endtask

    task automatic t_rc();
        hirc_busy = 1; wr(0, 'h1234); hirc_busy = 0;
        check("R2 hirc busy", 8'(flags[0]), 8'h1); clr_all();
        auxrc_busy = 1; wr(0, 'h1);
        check("R2 foreign busy", 8'(flags[0]), 8'h0);
        wr(1, 'h1);
        check("R2 aux busy", 8'(flags[0]), 8'h1); clr_all();
        auxrc_busy = 0;
    endtask

    task automatic t_xcfg();
        for (int a = 3; a <= 5; a++) begin
            xtal_busy = 1; wr(a, 'h55);
            check("R3 cfg busy", 8'(flags[0]), 8'h1); clr_all();
            xtal_busy = 0; wr(a, 'h55);
            check("R3 cfg idle", 8'(flags[0]), 8'h0);
        end
    endtask

    task automatic t_xmain();
        busy_all(1); xtal_on = 1; wr(2, 'hFFFF);
        xtal_on = 0; wr(2, 'h0);
        check("R4 main exempt", 8'(flags[0]), 8'h0);
        busy_all(0);
    endtask

    task automatic t_cmd();
        for (int k = 0; k < 4; k++) begin
            xtal_on = k[1]; xtal_busy = k[0];
            wr(8, 'h1);
            check("R5 enable", 8'(flags[0]), 8'(k == 3)); clr_all();
            wr(8, 'h2);
            check("R6 disable", 8'(flags[0]), 8'(k == 1)); clr_all();
        end
        xtal_on = 0; xtal_busy = 0;
    endtask

    task automatic t_lfrc();
        lfrc_busy = 1; wr(6, 'h0000); lfrc_busy = 0;
        check("R7 busy", 8'(flags[0]), 8'h1); clr_all();
        lfrc_ref_busy = 1; wr(6, 'h0500);
        check("R7 tune changed", 8'(flags[0]), 8'h1); clr_all();
        wr(6, 'hF5FF);
        check("R7 tune same", 8'(flags[0]), 8'h0);
        lfrc_ref_busy = 0; wr(6, 'h0700);
        check("R7 ref idle", 8'(flags[0]), 8'h0);
        lfrc_ref_busy = 1; wr(6, 'h0700);
        check("R7 shadow updated", 8'(flags[0]), 8'h0);
        lfrc_ref_busy = 0;
    endtask

    task automatic t_lfxt();
        lfxt_busy = 1; wr(7, 'h3);
        check("R8 busy", 8'(flags[0]), 8'h1); clr_all();
        lfxt_busy = 0; wr(7, 'h3);
        check("R8 idle", 8'(flags[0]), 8'h0);
    endtask

    task automatic t_irq();
        wr(9, 'h1);
        check("R9 masked", 8'(irq), 8'h0);
        wr(11, 'h1);
        check("R9 ien", 8'(ien), 8'h1);
        check("R9 enabled", 8'(irq), 8'h1);
        wr(11, 'h4);
        check("R9 other mask", 8'(irq), 8'h0);
        wr(9, 'h4);
        check("R9 bit2", 8'(irq), 8'h1);
        clr_all(); wr(11, 'h0);
        check("R9 cleared", 8'(irq), 8'h0);
    endtask

    task automatic t_sticky();
        wr(9, 'hA);
        repeat (4) @(negedge clk);
        check("R10 sticky", 8'(flags), 8'hA);
        wr(10, 'h8);
        check("R10 partial clear", 8'(flags), 8'h2);
        clr_all();
        check("R10 all clear", 8'(flags), 8'h0);
    endtask

    task automatic t_prio();
        wr(9, 'h2);
        @(negedge clk);
        hirc_busy = 1; wr_en = 1; wr_addr = 0; wr_data = '0;
        @(negedge clk);
        hirc_busy = 0; wr_addr = 4'(10); wr_data = 16'h3;
        check("R11 one edge", 8'(flags[0]), 8'h0);
        @(negedge clk);
        wr_en = 0;
        check("R11 set wins", 8'(flags), 8'h1);
        clr_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset(); t_rc(); t_xcfg(); t_xmain(); t_cmd();
        t_lfrc(); t_lfxt(); t_irq(); t_sticky(); t_prio();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule